// File: doc/BRIEF.md
# Serial Character Transmitter with Framing, Break and Flow Gating

This block turns characters handed to it by a host into an asynchronous serial bit stream on one output line. The host writes an 8-bit character into a one-deep holding register. When the shift stage is free and the peer allows sending, the character moves into the shift stage. It then goes out as a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. Bit timing comes from an external oversampling enable pulse: every bit lasts 16 of those pulses. The block has no baud divisor of its own.

The framing is chosen at run time by a word-length code, a stop-count bit and three parity bits (enable, even, stick). Together these give none, even, odd, mark or space parity. The framing is captured when a character enters the shift stage, so a setting changed during a character applies from the next character on. A break input holds the line at the spacing level for as long as it is set. An active-low clear-to-send input is looked at only between characters, after a synchroniser. Two flags tell the host whether the holding register can take a new character and whether everything has gone out on the line.

Top module: `sertx_top`

## Requirements
- R1: After reset the line `txd` is high (marking), and `hold_empty` and `tx_empty` are both 1.
- R2: A character is sent as one low start bit, then the data bits least significant bit first, then the parity bit if enabled, then high stop bits. Each bit lasts 16 pulses of `tick`.
- R3: `word_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `wr_data` above the selected length are not sent.
- R4: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. `tx_empty` stays 0 until the last stop bit has ended.
- R5: Parity bit. With `par_en` = 0 no parity bit is sent. With `par_en` = 1 and `par_stick` = 0, `par_even` = 1 gives even parity (the parity bit equals the XOR of the sent data bits) and `par_even` = 0 gives odd parity (the inverse of that XOR). With `par_stick` = 1 the parity bit is fixed: 1 when `par_even` = 0 (mark) and 0 when `par_even` = 1 (space).
- R6: A write makes `hold_empty` 0. `hold_empty` returns to 1 when the character moves into the shift stage, while `tx_empty` is still 0.
- R7: `tx_empty` is 1 only when the holding register is empty and the shift stage is idle.
- R8: A write while a character is waiting in the holding register replaces that character. Only the last one written is sent.
- R9: While `cts_n` is high, a waiting character is not started and the line stays high. Raising `cts_n` during a character does not stop that character: it completes in full.
- R10: While `brk` is 1, `txd` is low. The character in progress keeps its timing underneath, and the line returns to its normal value once `brk` is cleared.
- R11: If a write arrives in the same cycle that the held character moves into the shift stage, the held character is sent and the new one stays waiting. Both go out, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| word_len | input | 2 | Data length code (5 + value bits) |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | Even select (space when sticky) |
| par_stick | input | 1 | Fixed-value parity |
| brk | input | 1 | Force line low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
Two functions can fall in the same cycle: a host write to the holding register and the transfer of the held character into the shift stage. The bench provokes this by holding a character back with `cts_n` high. It then releases `cts_n` and asserts the write exactly on the edge where the synchroniser lets the transfer happen. The result is judged at the line: the first frame must carry the old character and the second the new one, and `hold_empty` must be 0 just after that edge. A second clash, break raised in the middle of a character, is judged by the time at which `tx_empty` rises.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  // Parity bit for the character, counting only the data bits that are sent.
  function automatic logic parity_bit(input logic [7:0] d, input frame_cfg_t c);
    logic [7:0] mask;
    logic       x;
    mask = 8'hFF >> (2'd3 - c.wlen);
    x    = ^(d & mask);
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? x : ~x;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
    end else if (wr_en) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R8/R11: a write always leaves a character waiting
  a_r8_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> full);
  // R11: a write that meets a transfer keeps the new data waiting
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && take) |=> (full && data == $past(wr_data)));
  // R6: a transfer with no write empties the holding register
  a_r6_take_clears: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> !full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  frame_cfg_t   cfg,
  output logic         idle,
  output logic         line
);

  localparam int TW   = $clog2(OVS);
  localparam int IW   = $clog2(W);
  localparam int MINW = W - 3;

  tx_state_e  state;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] bidx;
  logic [W-1:0]  sreg;
  frame_cfg_t    cfg_q;
  logic          par_q;
  logic          stop_left;
  logic          bit_end;
  logic [IW-1:0] last_idx;

  assign bit_end  = tick && (tcnt == TW'(OVS - 1));
  assign last_idx = IW'(MINW - 1) + IW'(cfg_q.wlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      sreg      <= '0;
      cfg_q     <= '0;
      par_q     <= 1'b0;
      stop_left <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (load) begin
        sreg  <= load_data;
        cfg_q <= cfg;
        par_q <= parity_bit(load_data, cfg);
        tcnt  <= '0;
        state <= ST_START;
      end
    end else if (tick) begin
      tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (state)
          ST_START: begin
            bidx  <= '0;
            state <= ST_DATA;
          end
          ST_DATA: begin
            sreg <= sreg >> 1;
            if (bidx == last_idx) begin
              stop_left <= cfg_q.two_stop;
              state     <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
          ST_PAR: begin
            stop_left <= cfg_q.two_stop;
            state     <= ST_STOP;
          end
          ST_STOP: begin
            if (stop_left) stop_left <= 1'b0;
            else           state     <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign idle = (state == ST_IDLE);

  // R2: bit timing only advances on the oversampling enable
  a_r2_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!idle && !tick) |=> $stable(tcnt));
  // R2: a load always opens with a start bit
  a_r2_load_starts: assert property (@(posedge clk) disable iff (rst)
    (idle && load) |=> (state == ST_START));
  // R4: stop phase ends only on a bit boundary
  a_r4_stop_on_tick: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP && !tick) |=> (state == ST_STOP));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk,
  input  logic              cts_n,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);

  logic              cts_blocked;
  logic              full;
  logic [DATA_W-1:0] held;
  logic              sh_idle;
  logic              line;
  logic              load;
  frame_cfg_t        cfg;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign cts_blocked = cts_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], cts_n} >> 0;
      end
      assign cts_blocked = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign cfg  = '{wlen: word_len, two_stop: two_stop, par_en: par_en,
                  par_even: par_even, par_stick: par_stick};
  assign load = sh_idle && full && !cts_blocked;

  sertx_hold #(.W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load),
    .data    (held),
    .full    (full)
  );

  sertx_shift #(.W(DATA_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (load),
    .load_data (held),
    .cfg       (cfg),
    .idle      (sh_idle),
    .line      (line)
  );

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= line && !brk;
  end

  assign hold_empty = !full;
  assign tx_empty   = sh_idle && !full;

  // R10: break forces the line low on the next edge
  a_r10_break_low: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);
  // R9: a deasserted clear-to-send keeps an idle shifter idle
  a_r9_cts_blocks: assert property (@(posedge clk) disable iff (rst)
    (cts_n && $past(cts_n) && $past(cts_n, 2) && sh_idle) |=> sh_idle);
  // R6: holding register frees up only while the shifter takes over
  a_r6_hold_before_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> !tx_empty);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = 2'd3;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       brk = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd;
  logic       hold_empty;
  logic       tx_empty;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .word_len(word_len), .two_stop(two_stop), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .brk(brk), .cts_n(cts_n),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // tick on every other cycle: 16 ticks = 32 clocks per bit
  always @(negedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= ~tick;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // {data[13:6], word_len[5:4], two_stop[3], par_en[2], par_even[1], par_stick[0]}
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h3C, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h00, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h5A, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h81, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hE7, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl,
                                   input logic ev, input logic st);
    logic ones;
    ones = 1'b0;
    for (int i = 0; i < 5 + wl; i++) ones ^= d[i];
    if (st) return !ev;
    return ev ? ones : !ones;
  endfunction

  // Receive one frame; returns at the middle of the last stop bit.
  task automatic rx_frame(input logic [1:0] wl, input logic pen, input logic two,
                          output logic [7:0] d, output logic p,
                          output logic start_ok, output logic stop_ok,
                          output logic seen);
    int wait_n;
    d = '0; p = 1'b0; start_ok = 1'b0; stop_ok = 1'b1; seen = 1'b0;
    wait_n = 0;
    while (txd !== 1'b0 && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    if (txd !== 1'b0) return;
    seen = 1'b1;
    clocks(15);
    start_ok = (txd == 1'b0);
    for (int i = 0; i < 5 + wl; i++) begin
      clocks(32);
      d[i] = txd;
    end
    if (pen) begin
      clocks(32);
      p = txd;
    end
    for (int s = 0; s < (two ? 2 : 1); s++) begin
      clocks(32);
      if (txd !== 1'b1) stop_ok = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] d, a, b;
    logic p, st_ok, sp_ok, seen;
    int lows;

    clocks(4);
    rst = 1'b0;
    clocks(2);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", hold_empty, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", tx_empty, 1);

    // Vector table: framing, data length, parity, stop count
    for (int v = 0; v < 8; v++) begin
      logic [13:0] e;
      e = VEC[v];
      word_len = e[5:4]; two_stop = e[3]; par_en = e[2];
      par_even = e[1];   par_stick = e[0];
      clocks(2);
      write(e[13:6]);
      rx_frame(e[5:4], e[2], e[3], d, p, st_ok, sp_ok, seen);
      chk(seen && st_ok, "R2 start bit low", {seen, st_ok}, 3);
      chk(d == (e[13:6] & mask_of(e[5:4])), "R3 data bits LSB first",
          d, e[13:6] & mask_of(e[5:4]));
      if (e[2])
        chk(p == exp_par(e[13:6], e[5:4], e[1], e[0]), "R5 parity bit",
            p, exp_par(e[13:6], e[5:4], e[1], e[0]));
      chk(sp_ok, "R2 stop bits high", sp_ok, 1);
      chk(tx_empty == 1'b0, "R4 busy in last stop bit", tx_empty, 0);
      clocks(32);
      chk(tx_empty == 1'b1 && txd == 1'b1, "R4 R7 idle after stop bits",
          {tx_empty, txd}, 3);
    end

    // R6: hold_empty falls on write, rises at transfer while still busy
    word_len = 2'd3; two_stop = 1'b0; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;
    clocks(4);
    write(8'h55);
    chk(hold_empty == 1'b0, "R6 hold_empty low after write", hold_empty, 0);
    clocks(3);
    chk(hold_empty == 1'b1 && tx_empty == 1'b0, "R6 R7 transfer flags",
        {hold_empty, tx_empty}, 2);
    rx_frame(2'd3, 1'b0, 1'b0, d, p, st_ok, sp_ok, seen);
    chk(d == 8'h55, "R6 frame after transfer", d, 8'h55);
    clocks(40);

    // R9 blocking and R8 overwrite
    cts_n = 1'b1;
    clocks(4);
    write(8'h12);
    clocks(300);
    chk(txd == 1'b1 && hold_empty == 1'b0 && tx_empty == 1'b0,
        "R9 R7 held while cts_n high", {txd, hold_empty, tx_empty}, 3'b100);
    write(8'h34);
    cts_n = 1'b0;
    rx_frame(2'd3, 1'b0, 1'b0, d, p, st_ok, sp_ok, seen);
    chk(d == 8'h34, "R8 pending character replaced", d, 8'h34);
    lows = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R8 only one frame sent", lows, 0);

    // R9: raising cts_n mid-character does not cut it short
    write(8'h6B);
    fork
      rx_frame(2'd3, 1'b0, 1'b0, d, p, st_ok, sp_ok, seen);
      begin clocks(100); cts_n = 1'b1; end
    join
    chk(d == 8'h6B && sp_ok, "R9 in-progress character completes", d, 8'h6B);
    cts_n = 1'b0;
    clocks(40);

    // R10: break at idle
    brk = 1'b1;
    clocks(2);
    chk(txd == 1'b0, "R10 break forces low at idle", txd, 0);
    brk = 1'b0;
    clocks(2);
    chk(txd == 1'b1, "R10 line high after break", txd, 1);

    // R10: break during a character, timing continues underneath
    write(8'hF0);
    clocks(100);
    brk = 1'b1;
    clocks(50);
    chk(txd == 1'b0, "R10 break low mid-character", txd, 0);
    clocks(50);
    brk = 1'b0;
    clocks(50);
    chk(tx_empty == 1'b0, "R10 character still running", tx_empty, 0);
    clocks(150);
    chk(tx_empty == 1'b1 && txd == 1'b1, "R10 character ends on time",
        {tx_empty, txd}, 3);

    // R11: write lands on the transfer edge
    a = 8'hC3; b = 8'h2D;
    cts_n = 1'b1;
    clocks(4);
    write(a);
    clocks(10);
    cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_data = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty == 1'b0, "R11 new character waiting", hold_empty, 0);
    rx_frame(2'd3, 1'b0, 1'b0, d, p, st_ok, sp_ok, seen);
    chk(d == a, "R11 first frame is old character", d, a);
    rx_frame(2'd3, 1'b0, 1'b0, d, p, st_ok, sp_ok, seen);
    chk(seen && d == b, "R11 second frame is new character", d, b);
    clocks(40);
    chk(tx_empty == 1'b1, "R7 empty after both frames", tx_empty, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule